// File: doc/BRIEF.md
# Oversampling UART Receiver with Three-Sample Vote

This block receives asynchronous serial frames on a single input line whose resting level is high. A frame is ten bit times long: one low start bit, eight data bits sent least-significant first, and one high stop bit. The system clock is divided by a programmable divisor plus one to make a sample tick. In normal mode each bit spans 16 ticks. In double-speed mode each bit spans 8 ticks.

Each bit is decided by a two-out-of-three vote over three consecutive ticks centred on the middle of the bit. In normal mode the samples are at ticks 7, 8 and 9. In double-speed mode they are at ticks 3, 4 and 5, so they cover a larger share of the bit. A falling edge is accepted as a start bit only if the vote at its centre is still low; otherwise the edge is dropped as noise.

When the stop bit has been voted, the byte is presented together with a one-cycle valid strobe. If the stop bit reads low, a framing-error flag is raised in that same cycle, and the receiver then waits for the line to go high again before it looks for another start bit. Software picks the divisor as round(F_clk / (ticks_per_bit × baud)) − 1. The package provides this computation, rounding to nearest instead of truncating.

Top module: `uart_rx_vote`

## Requirements
- R1: After reset, `rx_valid` and `rx_ferr` are low. The serial input reaches the sampler through a two-flop synchronizer. A line held high produces no output.
- R2: In normal mode (`dbl_speed` = 0) a tick occurs every `div_in`+1 clocks, and one bit lasts 16 ticks.
- R3: In double-speed mode (`dbl_speed` = 1) one bit lasts 8 ticks at the same tick rate.
- R4: Each bit value is the majority of the samples at ticks 7, 8 and 9 of the bit in normal mode, or at ticks 3, 4 and 5 in double-speed mode. Tick 0 of the start bit is the first tick that sees the line low. A disturbance that covers only one of the three samples does not change the bit.
- R5: The eight data bits are assembled least-significant bit first. `rx_data` is presented with `rx_valid` high for exactly one clock per frame.
- R6: If the start-bit vote reads high, the falling edge is rejected and no byte is produced.
- R7: If the stop-bit vote reads low, `rx_ferr` is high in the same cycle as `rx_valid`. The receiver produces nothing more until the line has been seen high again.
- R8: `div_in` and `dbl_speed` are captured only while the receiver is idle. A change during a frame does not affect that frame.
- R9: The package function `baud_divisor(f, baud, ovs)` returns (f + baud·ovs/2) / (baud·ovs) − 1, which is the rounded ratio minus one. For example, 16 MHz at 115200 baud with 16 ticks per bit gives 8.
- R10: Frames whose bit period differs from the nominal period by ±3% are still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| div_in | input | DIV_W | Divisor value; tick period is div_in+1 clocks |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe when a byte is ready |
| rx_ferr | output | 1 | Stop bit read low; valid only with rx_valid |

## Verification
The assertions assume that the configuration inputs change only while the line is idle, or that they are ignored when they change during a frame. They also assume that the serial line is not driven faster than the configured tick rate can resolve. The stimulus derives every bit period from the same divisor and mode it applies, within ±3%. It shortens pulses to a single tick period only to test noise rejection, and it changes the configuration mid-frame only to show that the change is ignored. After a framing error, the line is returned high before the next frame is sent.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
  } rx_state_e;

  // Rounded clock-to-tick ratio minus one (round half up).
  function automatic longint unsigned baud_divisor(longint unsigned f_clk,
                                                   longint unsigned baud,
                                                   longint unsigned ovs);
    longint unsigned den;
    den = baud * ovs;
    return ((f_clk + den / 2) / den) - 1;
  endfunction

  // Two-of-three majority.
  function automatic logic vote3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0) |=> (!tick || !$stable(div_q))) else $error("tick gap"); // R2
endmodule

// File: rtl/rx_core.sv
module rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS_N  = 16,
  parameter int OVS_D  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              dbl_q,
  output logic              is_idle,
  output logic [DATA_W-1:0] data_out,
  output logic              valid,
  output logic              ferr
);
  localparam int TW    = $clog2(OVS_N);
  localparam int BW    = $clog2(DATA_W + 1);
  localparam logic [TW-1:0] LAST_N = TW'(OVS_N - 1);
  localparam logic [TW-1:0] LAST_D = TW'(OVS_D - 1);
  localparam logic [TW-1:0] MID_N  = TW'(OVS_N / 2);
  localparam logic [TW-1:0] MID_D  = TW'(OVS_D / 2);

  rx_state_e         state;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              s_a, s_b, prev_rxd;

  // Named events for the checks.
  logic [TW-1:0] last_t, mid_t;
  logic at_first, at_mid, at_vote, at_last, vote_now, edge_seen;

  assign last_t    = dbl_q ? LAST_D : LAST_N;
  assign mid_t     = dbl_q ? MID_D  : MID_N;
  assign at_first  = tick && (tcnt == mid_t - 1'b1);
  assign at_mid    = tick && (tcnt == mid_t);
  assign at_vote   = tick && (tcnt == mid_t + 1'b1);
  assign at_last   = tick && (tcnt == last_t);
  assign vote_now  = vote3(s_a, s_b, rxd);
  assign edge_seen = tick && prev_rxd && !rxd;
  assign is_idle   = (state == RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      tcnt     <= '0;
      bitn     <= '0;
      shreg    <= '0;
      s_a      <= 1'b1;
      s_b      <= 1'b1;
      prev_rxd <= 1'b1;
      data_out <= '0;
      valid    <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      if (tick) prev_rxd <= rxd;
      case (state)
        RX_IDLE: begin
          if (edge_seen) begin
            state <= RX_START;
            tcnt  <= TW'(1);
          end
        end
        RX_WAIT_HIGH: begin
          if (tick && rxd) state <= RX_IDLE;
        end
        default: begin
          if (tick) tcnt <= at_last ? '0 : tcnt + 1'b1;
          if (at_first) s_a <= rxd;
          if (at_mid)   s_b <= rxd;
          if (at_vote) begin
            unique case (state)
              RX_START: if (vote_now) state <= RX_IDLE;
              RX_DATA: begin
                shreg <= {vote_now, shreg[DATA_W-1:1]};
                bitn  <= bitn + 1'b1;
              end
              RX_STOP: begin
                data_out <= shreg;
                valid    <= 1'b1;
                ferr     <= !vote_now;
                state    <= vote_now ? RX_IDLE : RX_WAIT_HIGH;
              end
              default: ;
            endcase
          end
          if (at_last) begin
            if (state == RX_START) begin
              state <= RX_DATA;
              bitn  <= '0;
            end else if (state == RX_DATA && bitn == BW'(DATA_W)) begin
              state <= RX_STOP;
            end
          end
        end
      endcase
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid) else $error("valid longer than one cycle"); // R5
  AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |-> valid) else $error("ferr without valid"); // R7
  AST_REARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAIT_HIGH && !rxd) |=> state != RX_IDLE) else $error("rearm while low"); // R7
  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && at_vote && vote_now) |=> (state == RX_IDLE && !valid)) else $error("glitch accepted"); // R6
  AST_VALID_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(state) == RX_STOP) else $error("valid outside stop"); // R5
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              dbl_speed,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr
);
  logic [DIV_W-1:0] div_q;
  logic             dbl_q;
  logic             core_idle, tick, rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      dbl_q <= 1'b0;
    end else if (core_idle) begin
      div_q <= div_in;
      dbl_q <= dbl_speed;
    end
  end

  rx_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rxd)
  );

  rx_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .tick(tick)
  );

  rx_core #(.DATA_W(DATA_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .dbl_q(dbl_q),
    .is_idle(core_idle), .data_out(rx_data), .valid(rx_valid), .ferr(rx_ferr)
  );

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_idle && $past(!core_idle)) |-> ($stable(div_q) && $stable(dbl_q))) else $error("config moved mid-frame"); // R8
endmodule

// File: tb/uart_rx_vote_tb_top.sv
module uart_rx_vote_tb_top;
  localparam int DIV_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_in = 1'b1;
  logic [DIV_W-1:0] div_in = 12'd3;
  logic             dbl_speed = 1'b0;
  logic [7:0]       rx_data;
  logic             rx_valid, rx_ferr;

  int tests = 0;
  int fails = 0;
  string cur_req = "R5";
  logic [8:0] exp_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  uart_rx_vote #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .div_in(div_in),
    .dbl_speed(dbl_speed), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(logic lvl, int n);
    rx_in <= lvl;
    repeat (n) @(posedge clk);
  endtask

  // Driver: pushes the expected item, then drives one frame.
  // glitch_bit >= 0 flips one tick period at the middle of that data bit.
  task automatic send_frame(logic [7:0] b, logic stop, int per, int glitch_bit, int tickp);
    exp_q.push_back({!stop, b});
    hold(1'b0, per);
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        hold(b[i], per / 2 - tickp / 2);
        hold(!b[i], tickp);
        hold(b[i], per - per / 2 - tickp / 2);
      end else begin
        hold(b[i], per);
      end
    end
    hold(stop, per);
    if (!stop) hold(1'b0, 2 * per);
    hold(1'b1, per);
  endtask

  // Monitor: pops and compares as results appear.
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected byte actual=%0h expected=none", cur_req, {rx_ferr, rx_data});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({rx_ferr, rx_data} !== e) begin
          fails++;
          $display("FAIL %s actual=%0h expected=%0h", cur_req, {rx_ferr, rx_data}, e);
        end
      end
    end
  end

  function automatic int own_div(real f, real baud, real ovs);
    return $rtoi(f / (baud * ovs) + 0.5) - 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9: divisor arithmetic
    check("R9", 32'(uart_rx_pkg::baud_divisor(16000000, 115200, 16)), 32'(own_div(16.0e6, 115200.0, 16.0)));
    check("R9", 32'(uart_rx_pkg::baud_divisor(16000000, 115200, 16)), 32'd8);
    check("R9", 32'(uart_rx_pkg::baud_divisor(16000000, 115200, 8)), 32'd16);
    check("R9", 32'(uart_rx_pkg::baud_divisor(18432000, 115200, 16)), 32'd9);

    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", {30'd0, rx_valid, rx_ferr}, 32'd0);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (400) @(posedge clk); // idle high: monitor flags any output
    @(negedge clk);
    check("R1", {30'd0, rx_valid, rx_ferr}, 32'd0);

    // R2/R5: normal mode, div 3 -> 64 clocks per bit
    cur_req = "R2_R5";
    send_frame(8'hA5, 1'b1, 64, -1, 4);
    send_frame(8'h01, 1'b1, 64, -1, 4);
    send_frame(8'h80, 1'b1, 64, -1, 4);
    send_frame(8'h00, 1'b1, 64, -1, 4);
    send_frame(8'hFF, 1'b1, 64, -1, 4);

    // R4: one-tick disturbance in a data bit, normal mode
    cur_req = "R4";
    send_frame(8'h3C, 1'b1, 64, 2, 4);
    send_frame(8'hC3, 1'b1, 64, 5, 4);

    // R3: double speed, div 7 -> 8 ticks of 8 clocks = 64 clocks
    div_in <= 12'd7; dbl_speed <= 1'b1;
    hold(1'b1, 40);
    cur_req = "R3";
    send_frame(8'h5A, 1'b1, 64, -1, 8);
    // R3/R4: double speed, div 3 -> 32 clocks per bit, glitch of one tick
    div_in <= 12'd3;
    hold(1'b1, 40);
    send_frame(8'h96, 1'b1, 32, -1, 4);
    cur_req = "R4";
    send_frame(8'h69, 1'b1, 32, 3, 4);

    // R6: short low pulses on the idle line
    dbl_speed <= 1'b0; div_in <= 12'd3;
    hold(1'b1, 40);
    cur_req = "R6";
    hold(1'b0, 8);
    hold(1'b1, 300);
    hold(1'b0, 12);
    hold(1'b1, 300);
    @(negedge clk);
    check("R6", exp_q.size(), 32'd0);

    // R7: framing error, line held low, then recovery frame
    cur_req = "R7";
    send_frame(8'h42, 1'b0, 64, -1, 4);
    send_frame(8'h24, 1'b1, 64, -1, 4);

    // R8: configuration change mid-frame is ignored
    cur_req = "R8";
    fork
      send_frame(8'hE7, 1'b1, 64, -1, 4);
      begin
        repeat (200) @(posedge clk);
        dbl_speed <= 1'b1; div_in <= 12'd1;
        repeat (200) @(posedge clk);
        dbl_speed <= 1'b0; div_in <= 12'd3;
      end
    join

    // R10: bit period off by about 3%
    cur_req = "R10";
    send_frame(8'hB1, 1'b1, 62, -1, 4);
    send_frame(8'h4E, 1'b1, 66, -1, 4);

    hold(1'b1, 200);
    @(negedge clk);
    check("R5", exp_q.size(), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule